// File: doc/BRIEF.md
# Command ring fetch controller

This block manages a circular command ring that feeds a copy engine. Software places 32-bit command words in a power-of-two sized ring in memory. It then moves a producer index forward by writing the write-pointer register. The block fetches words from memory one at a time, starting at its own consumer index and stopping when that index reaches the producer index. Each fetched word goes out on a valid/ready stream, in ring order. The block does not decode commands.

Each time a word is taken downstream, the consumer index moves forward by one and wraps at the ring size. The block can then report the new index to software by writing it to a programmable 40-bit memory location. When writebacks stall, several updates are merged into a single later write that carries the latest index.

The intended start-up order is to clear both pointers, program the base and the size, and then set the enable bit. Clearing the enable bit stops new fetches.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset every register reads as zero, and no memory read, no memory write and no stream word is presented.
- R2: Register map (word offsets on reg_addr):
  - 0, control: bit 0 is ring enable, bits 5:1 are log2 of the ring size in dwords, bit 8 is writeback enable.
  - 1: ring base as the byte address shifted right by 8.
  - 2 and 3: producer index and consumer index, each held in bits 17:2 and read back in bits 17:2.
  - 4: writeback address bits 31:2, with bits 1:0 reading zero.
  - 5: writeback address bits 39:32, in bits 7:0.
  - 6: status, with bit 0 busy.
  - Unused bits read zero.
- R3: Each fetch requests the byte address base*256 + 4*index. The request stays asserted with a stable address until it is granted, and only one fetch is outstanding at a time.
- R4: Fetched words appear on the command stream in ring order, each equal to the memory word at its address. The data holds stable while valid is high and ready is low.
- R5: The consumer index advances by one per accepted word and wraps modulo 2^size. When the two indexes are equal modulo the ring size, the ring is empty and no read is requested. The number of fetches equals the number of words accepted.
- R6: Bits of a producer-index write outside bits 17:2 are discarded. Index bits above the ring size are kept in the register but ignored when the two indexes are compared.
- R7: While ring enable is clear no new read is requested. A word that is already requested or held is still delivered.
- R8: A write to the consumer-index register takes effect only while ring enable is clear. While the ring is enabled the write is ignored.
- R9: With writeback enabled, each advance of the consumer index causes a memory write of the updated index, zero-extended, to the writeback address. The write holds stable until accepted. Advances made during a stalled write produce exactly one further write, which carries the latest index.
- R10: With writeback disabled no memory write is started.
- R11: The busy status bit is set exactly when the ring is enabled and the two indexes differ modulo the ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mrd_req | output | 1 | Ring word read request |
| mrd_addr | output | 40 | Ring word byte address |
| mrd_gnt | input | 1 | Read request accepted |
| mrd_rvalid | input | 1 | Read data returned |
| mrd_rdata | input | 32 | Returned ring word |
| mwr_valid | output | 1 | Index writeback request |
| mwr_addr | output | 40 | Writeback byte address |
| mwr_data | output | 32 | Updated consumer index |
| mwr_ready | input | 1 | Writeback accepted |
| cmd_valid | output | 1 | Fetched word valid |
| cmd_data | output | 32 | Fetched command word |
| cmd_ready | input | 1 | Downstream accepts the word |

## Verification
The fetch path is exercised with four kinds of producer advance:
- a short run from zero, which checks basic ordering;
- a run that passes the end of the ring, which separates a correct wrap from linear addressing;
- a write carrying junk bits and index bits above the ring size, which shows that masking happens on the comparison and not on the stored value;
- random advances over random sizes and bases, which shows whether the address arithmetic holds for every ring geometry.

Memory grants and downstream readiness are randomised throughout, so that a handshake which loses or repeats a word shows up in the word count.

Directed phases isolate the remaining behaviours:
- disabling the ring while a word is held separates "finish the in-flight word" from both dropping it and continuing to fetch;
- a consumer-index write is made both while enabled and while disabled;
- a stalled writeback during a burst of advances tells one merged write carrying the latest index apart from one write per advance.

// File: rtl/ring_pkg.sv
package ring_pkg;
    // register word offsets
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_BASE = 3'd1;
    localparam logic [2:0] RA_WPTR = 3'd2;
    localparam logic [2:0] RA_RPTR = 3'd3;
    localparam logic [2:0] RA_WBLO = 3'd4;
    localparam logic [2:0] RA_WBHI = 3'd5;
    localparam logic [2:0] RA_STAT = 3'd6;

    // control field positions
    localparam int CTL_EN     = 0;
    localparam int CTL_SZ_LSB = 1;
    localparam int CTL_WB     = 8;

    // index fields sit above the byte offset bits
    localparam int PTR_LSB = 2;
    localparam int MEM_AW  = 40;
    localparam int BASE_SH = 8;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_WAIT = 2'd2,
        F_HOLD = 2'd3
    } fetch_st_e;
endpackage

// File: rtl/ring_regs.sv
module ring_regs
    import ring_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int SZ_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    input  logic [PTR_W-1:0]     rptr,
    input  logic                 busy,
    output logic                 ring_en,
    output logic                 wb_en,
    output logic [SZ_W-1:0]      size_log2,
    output logic [31:0]          base,
    output logic [PTR_W-1:0]     wptr,
    output logic [MEM_AW-1:0]    wb_addr,
    output logic                 rptr_wr,
    output logic [PTR_W-1:0]     rptr_wdata,
    output logic [31:0]          reg_rdata
);
    typedef struct packed {
        logic             en;
        logic             wben;
        logic [SZ_W-1:0]  size;
        logic [31:0]      base;
        logic [PTR_W-1:0] wptr;
        logic [29:0]      wblo;
        logic [7:0]       wbhi;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    r_d.en   = reg_wdata[CTL_EN];
                    r_d.size = reg_wdata[CTL_SZ_LSB +: SZ_W];
                    r_d.wben = reg_wdata[CTL_WB];
                end
                RA_BASE: r_d.base = reg_wdata;
                RA_WPTR: r_d.wptr = reg_wdata[PTR_LSB +: PTR_W];
                RA_WBLO: r_d.wblo = reg_wdata[31:2];
                RA_WBHI: r_d.wbhi = reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTL_EN]               = r_q.en;
                reg_rdata[CTL_SZ_LSB +: SZ_W]   = r_q.size;
                reg_rdata[CTL_WB]               = r_q.wben;
            end
            RA_BASE: reg_rdata                      = r_q.base;
            RA_WPTR: reg_rdata[PTR_LSB +: PTR_W]    = r_q.wptr;
            RA_RPTR: reg_rdata[PTR_LSB +: PTR_W]    = rptr;
            RA_WBLO: reg_rdata[31:2]                = r_q.wblo;
            RA_WBHI: reg_rdata[7:0]                 = r_q.wbhi;
            RA_STAT: reg_rdata[0]                   = busy;
            default: ;
        endcase
    end

    // consumer index may only be loaded while the ring is stopped
    assign rptr_wr    = reg_wr && (reg_addr == RA_RPTR) && !r_q.en;
    assign rptr_wdata = reg_wdata[PTR_LSB +: PTR_W];

    assign ring_en   = r_q.en;
    assign wb_en     = r_q.wben;
    assign size_log2 = r_q.size;
    assign base      = r_q.base;
    assign wptr      = r_q.wptr;
    assign wb_addr   = {r_q.wbhi, r_q.wblo, 2'b00};
endmodule

// File: rtl/ring_fetch.sv
module ring_fetch
    import ring_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int SZ_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ring_en,
    input  logic [SZ_W-1:0]    size_log2,
    input  logic [31:0]        base,
    input  logic [PTR_W-1:0]   wptr,
    input  logic               rptr_wr,
    input  logic [PTR_W-1:0]   rptr_wdata,
    output logic               mrd_req,
    output logic [MEM_AW-1:0]  mrd_addr,
    input  logic               mrd_gnt,
    input  logic               mrd_rvalid,
    input  logic [31:0]        mrd_rdata,
    output logic               cmd_valid,
    output logic [31:0]        cmd_data,
    input  logic               cmd_ready,
    output logic [PTR_W-1:0]   rptr,
    output logic               adv,
    output logic [PTR_W-1:0]   adv_ptr,
    output logic               empty
);
    typedef struct packed {
        fetch_st_e          st;
        logic [PTR_W-1:0]   rptr;
        logic [MEM_AW-1:0]  addr;
        logic [31:0]        data;
    } fetch_t;

    fetch_t f_d, f_q;

    logic [PTR_W-1:0]  mask;
    logic [PTR_W-1:0]  rptr_m;
    logic [PTR_W-1:0]  step;
    logic [MEM_AW-1:0] word_addr;
    logic              accept;

    always_comb begin
        if (int'(size_log2) >= PTR_W) mask = '1;
        else                          mask = (PTR_W'(1) << size_log2) - PTR_W'(1);
    end

    assign rptr_m    = f_q.rptr & mask;
    assign step      = (rptr_m + PTR_W'(1)) & mask;
    assign empty     = (rptr_m == (wptr & mask));
    assign word_addr = {base, {BASE_SH{1'b0}}} + MEM_AW'({rptr_m, 2'b00});

    always_comb begin
        f_d    = f_q;
        accept = 1'b0;
        case (f_q.st)
            F_IDLE: begin
                if (ring_en && !empty) begin
                    f_d.st   = F_REQ;
                    f_d.addr = word_addr;
                end
            end
            F_REQ: begin
                if (mrd_gnt) f_d.st = F_WAIT;
            end
            F_WAIT: begin
                if (mrd_rvalid) begin
                    f_d.st   = F_HOLD;
                    f_d.data = mrd_rdata;
                end
            end
            F_HOLD: begin
                if (cmd_ready) begin
                    accept   = 1'b1;
                    f_d.st   = F_IDLE;
                    f_d.rptr = step;
                end
            end
            default: f_d.st = F_IDLE;
        endcase
        if (rptr_wr) f_d.rptr = rptr_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign mrd_req   = (f_q.st == F_REQ);
    assign mrd_addr  = f_q.addr;
    assign cmd_valid = (f_q.st == F_HOLD);
    assign cmd_data  = f_q.data;
    assign rptr      = f_q.rptr;
    assign adv       = accept;
    assign adv_ptr   = step;
endmodule

// File: rtl/ring_wb.sv
module ring_wb
    import ring_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wb_en,
    input  logic [MEM_AW-1:0]  wb_addr,
    input  logic               adv,
    input  logic [PTR_W-1:0]   adv_ptr,
    input  logic [PTR_W-1:0]   cur_ptr,
    output logic               mwr_valid,
    output logic [MEM_AW-1:0]  mwr_addr,
    output logic [31:0]        mwr_data,
    input  logic               mwr_ready
);
    typedef struct packed {
        logic               busy;
        logic               dirty;
        logic [MEM_AW-1:0]  addr;
        logic [PTR_W-1:0]   data;
    } wb_t;

    wb_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (w_q.busy && mwr_ready) begin
            if ((w_q.dirty || adv) && wb_en) begin
                // merged follow-up write with the newest index
                w_d.data  = adv ? adv_ptr : cur_ptr;
                w_d.addr  = wb_addr;
                w_d.dirty = 1'b0;
            end else begin
                w_d.busy  = 1'b0;
                w_d.dirty = 1'b0;
            end
        end else if (w_q.busy && adv) begin
            w_d.dirty = 1'b1;
        end else if (!w_q.busy && adv && wb_en) begin
            w_d.busy = 1'b1;
            w_d.data = adv_ptr;
            w_d.addr = wb_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign mwr_valid = w_q.busy;
    assign mwr_addr  = w_q.addr;
    assign mwr_data  = {{(32-PTR_W){1'b0}}, w_q.data};
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
    import ring_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int SZ_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mrd_req,
    output logic [MEM_AW-1:0]  mrd_addr,
    input  logic               mrd_gnt,
    input  logic               mrd_rvalid,
    input  logic [31:0]        mrd_rdata,
    output logic               mwr_valid,
    output logic [MEM_AW-1:0]  mwr_addr,
    output logic [31:0]        mwr_data,
    input  logic               mwr_ready,
    output logic               cmd_valid,
    output logic [31:0]        cmd_data,
    input  logic               cmd_ready
);
    logic               ring_en;
    logic               wb_en;
    logic [SZ_W-1:0]    size_log2;
    logic [31:0]        base;
    logic [PTR_W-1:0]   wptr;
    logic [MEM_AW-1:0]  wb_addr;
    logic               rptr_wr;
    logic [PTR_W-1:0]   rptr_wdata;
    logic [PTR_W-1:0]   rptr;
    logic               adv;
    logic [PTR_W-1:0]   adv_ptr;
    logic               empty;
    logic               busy;

    assign busy = ring_en && !empty;

    ring_regs #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .rptr       (rptr),
        .busy       (busy),
        .ring_en    (ring_en),
        .wb_en      (wb_en),
        .size_log2  (size_log2),
        .base       (base),
        .wptr       (wptr),
        .wb_addr    (wb_addr),
        .rptr_wr    (rptr_wr),
        .rptr_wdata (rptr_wdata),
        .reg_rdata  (reg_rdata)
    );

    ring_fetch #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_en    (ring_en),
        .size_log2  (size_log2),
        .base       (base),
        .wptr       (wptr),
        .rptr_wr    (rptr_wr),
        .rptr_wdata (rptr_wdata),
        .mrd_req    (mrd_req),
        .mrd_addr   (mrd_addr),
        .mrd_gnt    (mrd_gnt),
        .mrd_rvalid (mrd_rvalid),
        .mrd_rdata  (mrd_rdata),
        .cmd_valid  (cmd_valid),
        .cmd_data   (cmd_data),
        .cmd_ready  (cmd_ready),
        .rptr       (rptr),
        .adv        (adv),
        .adv_ptr    (adv_ptr),
        .empty      (empty)
    );

    ring_wb #(.PTR_W(PTR_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_en     (wb_en),
        .wb_addr   (wb_addr),
        .adv       (adv),
        .adv_ptr   (adv_ptr),
        .cur_ptr   (rptr),
        .mwr_valid (mwr_valid),
        .mwr_addr  (mwr_addr),
        .mwr_data  (mwr_data),
        .mwr_ready (mwr_ready)
    );
endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ring_en,
    input logic        wb_en,
    input logic        mrd_req,
    input logic        mrd_gnt,
    input logic [39:0] mrd_addr,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [31:0] cmd_data,
    input logic        mwr_valid,
    input logic        mwr_ready,
    input logic [39:0] mwr_addr,
    input logic [31:0] mwr_data
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req && !mrd_gnt |=> mrd_req && $stable(mrd_addr));

    // R3
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req && mrd_gnt |=> !mrd_req);

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

    // R9
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_valid && !mwr_ready |=> mwr_valid && $stable(mwr_addr) && $stable(mwr_data));

    // R10
    wb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en && !mwr_valid |=> !mwr_valid);

    // R7
    stopped_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_en && !mrd_req |=> !mrd_req);
endmodule

bind cmd_ring_fetch ring_fetch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_en   (ring_en),
    .wb_en     (wb_en),
    .mrd_req   (mrd_req),
    .mrd_gnt   (mrd_gnt),
    .mrd_addr  (mrd_addr),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .mwr_valid (mwr_valid),
    .mwr_ready (mwr_ready),
    .mwr_addr  (mwr_addr),
    .mwr_data  (mwr_data)
);

// File: tb/cmd_ring_fetch_bench.sv
`timescale 1ns/1ps
module cmd_ring_fetch_bench;
    import ring_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mrd_req;
    logic [39:0] mrd_addr;
    logic        mrd_gnt = 1'b0;
    logic        mrd_rvalid = 1'b0;
    logic [31:0] mrd_rdata = '0;
    logic        mwr_valid;
    logic [39:0] mwr_addr;
    logic [31:0] mwr_data;
    logic        mwr_ready = 1'b0;
    logic        cmd_valid;
    logic [31:0] cmd_data;
    logic        cmd_ready = 1'b0;

    cmd_ring_fetch u_cmd_ring_fetch (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
        .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
        .mwr_valid(mwr_valid), .mwr_addr(mwr_addr), .mwr_data(mwr_data),
        .mwr_ready(mwr_ready), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // bench model of the ring
    logic [31:0] b_base = '0;
    int          b_size = 0;
    int          b_rptr = 0;
    logic [39:0] b_wbaddr = '0;
    int          words_seen = 0;
    int          req_seen = 0;
    int          wb_writes = 0;
    int          last_wb = 0;
    int          ready_mode = 0;   // 0 random, 1 held low
    int          wready_mode = 0;  // 0 random, 1 held low

    logic        pend = 1'b0;
    logic [31:0] pend_data = '0;
    logic        prev_cmd_hold = 1'b0;
    logic [31:0] prev_cmd_data = '0;
    logic        prev_wb_hold = 1'b0;
    logic [31:0] prev_wb_data = '0;
    logic [39:0] prev_wb_addr = '0;

    function automatic logic [39:0] faddr(logic [31:0] b, int idx);
        return {b, 8'h00} + 40'(idx) * 40'd4;
    endfunction

    function automatic logic [31:0] mem_word(logic [39:0] a);
        return (a[31:0] * 32'h9E37_79B1) + {24'h0, a[39:32]};
    endfunction

    function automatic int ring_mask(int sz);
        return (1 << sz) - 1;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // environment: memory, downstream and writeback sink, all driven at negedge
    always @(negedge clk) begin
        if (rst_n) begin
            cmd_ready = (ready_mode == 1) ? 1'b0 : (($urandom % 4) != 0);
            mwr_ready = (wready_mode == 1) ? 1'b0 : (($urandom % 2) != 0);

            if (prev_cmd_hold)
                chk(cmd_valid && (cmd_data == prev_cmd_data), "R4", "stalled word stable",
                    cmd_data, prev_cmd_data);
            if (cmd_valid && cmd_ready) begin
                chk(cmd_data == mem_word(faddr(b_base, b_rptr)), "R4", "word in ring order",
                    cmd_data, mem_word(faddr(b_base, b_rptr)));
                b_rptr = (b_rptr + 1) & ring_mask(b_size);
                words_seen++;
            end
            prev_cmd_hold = cmd_valid && !cmd_ready;
            prev_cmd_data = cmd_data;

            mrd_rvalid = pend;
            mrd_rdata  = pend_data;
            mrd_gnt    = (($urandom % 3) != 0);
            if (mrd_req && mrd_gnt) begin
                chk(mrd_addr == faddr(b_base, b_rptr), "R3", "fetch address",
                    mrd_addr, faddr(b_base, b_rptr));
                pend      = 1'b1;
                pend_data = mem_word(mrd_addr);
                req_seen++;
            end else begin
                pend = 1'b0;
            end

            if (prev_wb_hold)
                chk(mwr_valid && (mwr_data == prev_wb_data) && (mwr_addr == prev_wb_addr),
                    "R9", "stalled writeback stable", mwr_data, prev_wb_data);
            if (mwr_valid && mwr_ready) begin
                chk(mwr_addr == b_wbaddr, "R9", "writeback address", mwr_addr, b_wbaddr);
                last_wb = int'(mwr_data);
                wb_writes++;
            end
            prev_wb_hold = mwr_valid && !mwr_ready;
            prev_wb_data = mwr_data;
            prev_wb_addr = mwr_addr;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        bit done = 1'b0;
        for (int i = 0; i < 3000 && !done; i++) begin
            rd(RA_STAT, v);
            if (!v[0]) done = 1'b1;
        end
        chk(done, "R11", "ring drained", 0, 0);
        repeat (30) @(negedge clk);
    endtask

    // advance the producer index with a raw register value and check the outcome
    task automatic push(input logic [31:0] raw, input bit wb_on);
        logic [31:0] v;
        int widx, m, exp_n, w0, q0;
        widx  = int'(raw[17:2]);
        m     = ring_mask(b_size);
        exp_n = ((widx & m) - b_rptr) & m;
        w0    = words_seen;
        q0    = req_seen;
        wr(RA_WPTR, raw);
        rd(RA_STAT, v);
        chk(v[0] == (exp_n != 0), "R11", "busy after producer write", v[0], exp_n != 0);
        wait_idle();
        chk(words_seen - w0 == exp_n, "R5", "words fetched", words_seen - w0, exp_n);
        chk(req_seen - q0 == exp_n, "R5", "reads requested", req_seen - q0, exp_n);
        rd(RA_RPTR, v);
        chk(v == 32'((widx & m) << 2), "R5", "consumer index", v, (widx & m) << 2);
        rd(RA_WPTR, v);
        chk(v == 32'(widx << 2), "R6", "producer index readback", v, widx << 2);
        if (wb_on && exp_n != 0)
            chk(last_wb == (widx & m), "R9", "written-back index", last_wb, widx & m);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int w0, q0, b0;
        void'($urandom(32'd20240611));

        // R1 reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk(v == 32'h0, "R1", "register after reset", v, 0);
        end
        chk(!mrd_req && !mwr_valid && !cmd_valid, "R1", "idle outputs in reset",
            {mrd_req, mwr_valid, cmd_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 programming and readback
        b_base   = 32'h0012_3456;
        b_wbaddr = 40'hA5_0000_1000;
        b_size   = 4;
        wr(RA_BASE, b_base);
        wr(RA_WBLO, 32'h0000_1003);
        wr(RA_WBHI, 32'h0000_01A5);
        wr(RA_CTRL, 32'h0000_0109);
        rd(RA_BASE, v); chk(v == b_base, "R2", "base readback", v, b_base);
        rd(RA_WBLO, v); chk(v == 32'h1000, "R2", "writeback low readback", v, 32'h1000);
        rd(RA_WBHI, v); chk(v == 32'hA5, "R2", "writeback high readback", v, 32'hA5);
        rd(RA_CTRL, v); chk(v == 32'h109, "R2", "control readback", v, 32'h109);
        rd(RA_STAT, v); chk(v == 32'h0, "R11", "idle when indexes equal", v, 0);

        // R5 plain run, then a run through the end of the ring
        push(32'd5 << 2, 1'b1);
        push(32'd3 << 2, 1'b1);

        // R6 junk bits and index bits above the ring size
        push(32'hF000_001F, 1'b1);
        push(32'd25 << 2, 1'b1);

        // R8 consumer write ignored while enabled
        wr(RA_RPTR, 32'h0);
        rd(RA_RPTR, v); chk(v == 32'd9 << 2, "R8", "index kept while enabled", v, 9 << 2);

        // R10 no writeback while disabled
        wr(RA_CTRL, 32'h0000_0009);
        b0 = wb_writes;
        push(32'd14 << 2, 1'b0);
        chk(wb_writes == b0, "R10", "writebacks with writeback off", wb_writes - b0, 0);
        wr(RA_CTRL, 32'h0000_0109);

        // R7 stopped ring fetches nothing
        wr(RA_CTRL, 32'h0000_0108);
        w0 = words_seen; q0 = req_seen;
        wr(RA_WPTR, 32'd2 << 2);
        repeat (40) @(negedge clk);
        chk(words_seen == w0, "R7", "words while stopped", words_seen - w0, 0);
        chk(req_seen == q0, "R7", "reads while stopped", req_seen - q0, 0);
        rd(RA_STAT, v); chk(v == 32'h0, "R11", "not busy while stopped", v, 0);

        // R8 consumer write honoured while stopped
        wr(RA_RPTR, 32'd1 << 2);
        rd(RA_RPTR, v); chk(v == 32'd1 << 2, "R8", "index loaded while stopped", v, 1 << 2);
        b_rptr = 1;
        w0 = words_seen;
        wr(RA_CTRL, 32'h0000_0109);
        wait_idle();
        chk(words_seen - w0 == 1, "R5", "words after restart", words_seen - w0, 1);

        // R7 stop while a word is held downstream
        ready_mode = 1;
        w0 = words_seen; q0 = req_seen;
        wr(RA_WPTR, 32'd10 << 2);
        for (int i = 0; i < 200 && !cmd_valid; i++) @(negedge clk);
        wr(RA_CTRL, 32'h0000_0108);
        repeat (5) @(negedge clk);
        ready_mode = 0;
        repeat (40) @(negedge clk);
        chk(words_seen - w0 == 1, "R7", "in-flight word delivered", words_seen - w0, 1);
        chk(req_seen - q0 == 1, "R7", "no read after stop", req_seen - q0, 1);
        rd(RA_RPTR, v); chk(v == 32'd3 << 2, "R7", "index after stop", v, 3 << 2);
        w0 = words_seen;
        wr(RA_CTRL, 32'h0000_0109);
        wait_idle();
        chk(words_seen - w0 == 7, "R5", "words after resume", words_seen - w0, 7);

        // R9 merged writeback while the sink stalls
        wready_mode = 1;
        b0 = wb_writes;
        push(32'd15 << 2, 1'b0);
        chk(mwr_valid && mwr_data == 32'd11, "R9", "first write held", mwr_data, 11);
        wready_mode = 0;
        repeat (30) @(negedge clk);
        chk(wb_writes - b0 == 2, "R9", "merged write count", wb_writes - b0, 2);
        chk(last_wb == 15, "R9", "merged write carries latest index", last_wb, 15);

        // random producer advances over random ring geometries
        for (int it = 0; it < 24; it++) begin
            if (it % 6 == 0) begin
                wr(RA_CTRL, 32'h0);
                wr(RA_RPTR, 32'h0);
                wr(RA_WPTR, 32'h0);
                repeat (30) @(negedge clk);
                b_size = 2 + int'($urandom % 5);
                b_base = $urandom;
                b_rptr = 0;
                wr(RA_BASE, b_base);
                wr(RA_CTRL, 32'h101 | 32'(b_size << 1));
            end
            push($urandom, 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule